// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a byte-wide bank of control registers reached through a plain register-access port: an 8-bit address, a write strobe with write data, and a read strobe with registered read data. Several of the control registers have three consecutive addresses. The base address overwrites the register. The next address ORs bits in. The address after that clears bits. Software can therefore change single bits without a read-modify-write sequence.

Every register keeps only the bits it implements. Each one has a fixed mask, and bits outside the mask always read as zero. The clock-status byte is not stored. It is computed on each read, by priority, from a PHY power-down bit, a clock-request bit and a suspend bit in the function-control register. Two identification bytes and the status byte are read-only. Every other address is unimplemented: it reads as zero and ignores writes. A synchronous active-high reset loads the defined default values.

Top module: `sacr_bank`

## Requirements
- R1: After reset, the registers hold these values: function control 0x40, interface control 0x00, auxiliary control 0x00, power control 0x20, PHY power 0x00, clock request 0x00. The read data output is 0x00.
- R2: A write to a triplet base address stores data AND mask. The bases and masks are: function control 0x10 with mask 0x7f, interface control 0x14 with mask 0x9e, auxiliary control 0x18 with mask 0x3f, power control 0x1c with mask 0x20.
- R3: A write to base+1 stores (current OR data) AND mask.
- R4: A write to base+2 stores (current AND NOT data) AND mask.
- R5: A read of any of the three addresses of a triplet returns the register's current value.
- R6: The PHY power register at 0x20 keeps only data bit 0. The clock-request register at 0x21 keeps only data bits 2:0. Each reads back at its own address.
- R7: A read of 0x22 works by priority. It returns 0x00 when PHY power bit 0 is 1. Otherwise it returns 0x01 when clock-request bit 0 is 1. Otherwise it returns function-control bit 6 in bit position 0, with the upper bits zero.
- R8: The identification bytes read as 0x5a at 0x00 and 0xc3 at 0x01. Writes to 0x00, 0x01 and 0x22 change no register.
- R9: A read of any other unimplemented address returns 0x00. A write to such an address changes no register.
- R10: Read data appears in the cycle after the read strobe and holds while no strobe is given. A read given in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A write strobe sampled at one clock edge changes the register at that same edge. A read strobe sampled at an edge puts its data on rdata at that edge, so a result is visible one edge after the strobe. The bench drives every strobe at a falling edge, removes it at the next falling edge, and samples rdata at that point: one rising edge after the read. Reads that chase a write therefore see the updated value, except in the deliberate same-cycle read-and-write case, which is expected to return the old value.

// File: rtl/sacr_pkg.sv
package sacr_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NUM_TRIP = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR
    } op_e;

    localparam addr_t ID_LO_A = 8'h00;
    localparam addr_t ID_HI_A = 8'h01;
    localparam byte_t ID_LO_V = 8'h5a;
    localparam byte_t ID_HI_V = 8'hc3;

    localparam addr_t PHY_A    = 8'h20;
    localparam byte_t PHY_MASK = 8'h01;
    localparam byte_t PHY_RST  = 8'h00;
    localparam addr_t CKQ_A    = 8'h21;
    localparam byte_t CKQ_MASK = 8'h07;
    localparam byte_t CKQ_RST  = 8'h00;
    localparam addr_t STAT_A   = 8'h22;

    localparam int SUSP_BIT = 6;

    // Triplet table: 0 function, 1 interface, 2 auxiliary, 3 power
    function automatic addr_t trip_base(int i);
        case (i)
            0:       return 8'h10;
            1:       return 8'h14;
            2:       return 8'h18;
            default: return 8'h1c;
        endcase
    endfunction

    function automatic byte_t trip_mask(int i);
        case (i)
            0:       return 8'h7f;
            1:       return 8'h9e;
            2:       return 8'h3f;
            default: return 8'h20;
        endcase
    endfunction

    function automatic byte_t trip_rst(int i);
        case (i)
            0:       return 8'h40;
            1:       return 8'h00;
            2:       return 8'h00;
            default: return 8'h20;
        endcase
    endfunction

    function automatic byte_t apply_op(op_e op, byte_t cur, byte_t d, byte_t mask);
        case (op)
            OP_LOAD: return d & mask;
            OP_SET:  return (cur | d) & mask;
            OP_CLR:  return (cur & ~d) & mask;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/sacr_ctl_reg.sv
module sacr_ctl_reg
    import sacr_pkg::*;
#(
    parameter addr_t BASE    = '0,
    parameter byte_t MASK    = '1,
    parameter byte_t RST     = '0,
    parameter bit    ALIASES = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  addr_t addr,
    input  byte_t wdata,
    output byte_t q,
    output logic  hit
);
    localparam addr_t SET_A = addr_t'(BASE + 1);
    localparam addr_t CLR_A = addr_t'(BASE + 2);

    op_e op;

    always_comb begin
        op = OP_NONE;
        if (wr_en) begin
            if (addr == BASE)
                op = OP_LOAD;
            else if (ALIASES && addr == SET_A)
                op = OP_SET;
            else if (ALIASES && addr == CLR_A)
                op = OP_CLR;
        end
    end

    assign hit = (addr == BASE) || (ALIASES && (addr == SET_A || addr == CLR_A));

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST & MASK;
        else
            q <= apply_op(op, q, wdata, MASK);
    end
endmodule

// File: rtl/sacr_stat.sv
module sacr_stat
    import sacr_pkg::*;
(
    input  byte_t phy_q,
    input  byte_t ckq_q,
    input  byte_t fctl_q,
    output byte_t stat
);
    always_comb begin
        stat = '0;
        if (phy_q[0])
            stat[0] = 1'b0;
        else if (ckq_q[0])
            stat[0] = 1'b1;
        else
            stat[0] = fctl_q[SUSP_BIT];
    end
endmodule

// File: rtl/sacr_bank.sv
module sacr_bank
    import sacr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    byte_t                trip_q   [NUM_TRIP];
    logic  [NUM_TRIP-1:0] trip_hit;
    byte_t                phy_q;
    byte_t                ckq_q;
    logic                 phy_hit;
    logic                 ckq_hit;
    byte_t                stat;
    byte_t                rd_next;

    for (genvar g = 0; g < NUM_TRIP; g++) begin : g_trip
        sacr_ctl_reg #(
            .BASE   (trip_base(g)),
            .MASK   (trip_mask(g)),
            .RST    (trip_rst(g)),
            .ALIASES(1'b1)
        ) u_reg (
            .clk  (clk),
            .rst  (rst),
            .wr_en(wr_en),
            .addr (addr),
            .wdata(wdata),
            .q    (trip_q[g]),
            .hit  (trip_hit[g])
        );
    end

    sacr_ctl_reg #(
        .BASE(PHY_A), .MASK(PHY_MASK), .RST(PHY_RST), .ALIASES(1'b0)
    ) u_phy (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .q(phy_q), .hit(phy_hit)
    );

    sacr_ctl_reg #(
        .BASE(CKQ_A), .MASK(CKQ_MASK), .RST(CKQ_RST), .ALIASES(1'b0)
    ) u_ckq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .q(ckq_q), .hit(ckq_hit)
    );

    sacr_stat u_stat (
        .phy_q (phy_q),
        .ckq_q (ckq_q),
        .fctl_q(trip_q[0]),
        .stat  (stat)
    );

    always_comb begin
        rd_next = '0;
        if (addr == ID_LO_A)
            rd_next = ID_LO_V;
        else if (addr == ID_HI_A)
            rd_next = ID_HI_V;
        else if (addr == STAT_A)
            rd_next = stat;
        else if (phy_hit)
            rd_next = phy_q;
        else if (ckq_hit)
            rd_next = ckq_q;
        else begin
            for (int i = 0; i < NUM_TRIP; i++)
                if (trip_hit[i])
                    rd_next = trip_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end
endmodule

// File: rtl/sacr_bank_chk.sv
module sacr_bank_chk
    import sacr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] fctl_q,
    input logic [7:0] ictl_q,
    input logic [7:0] phy_q,
    input logic [7:0] ckq_q
);
    assert_direct_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == 8'h10 |=> fctl_q == ($past(wdata) & 8'h7f));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == 8'h11 |=> fctl_q == (($past(fctl_q) | $past(wdata)) & 8'h7f));

    assert_clear_alias_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == 8'h16 |=> ictl_q == ($past(ictl_q) & ~$past(wdata) & 8'h9e));

    assert_phy_wins_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == STAT_A && phy_q[0] |=> rdata == 8'h00);

    assert_clkreq_next_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == STAT_A && !phy_q[0] && ckq_q[0] |=> rdata == 8'h01);

    assert_unimpl_read_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == 8'hf0 |=> rdata == 8'h00);

    assert_idle_regs_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(fctl_q) && $stable(ictl_q) && $stable(phy_q) && $stable(ckq_q));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

bind sacr_bank sacr_bank_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .fctl_q(trip_q[0]),
    .ictl_q(trip_q[1]),
    .phy_q (phy_q),
    .ckq_q (ckq_q)
);

// File: tb/sacr_bank_tb.sv
module sacr_bank_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       rd_en, wr_en;
    logic [7:0] addr, wdata;
    logic [7:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] t_base [4] = '{8'h10, 8'h14, 8'h18, 8'h1c};
    logic [7:0] t_mask [4] = '{8'h7f, 8'h9e, 8'h3f, 8'h20};
    logic [7:0] t_rst  [4] = '{8'h40, 8'h00, 8'h00, 8'h20};
    logic [7:0] m_trip [4];
    logic [7:0] m_phy, m_ckq;

    always #10 clk = ~clk;

    sacr_bank u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a == 8'h00) return 8'h5a;
        if (a == 8'h01) return 8'hc3;
        if (a == 8'h20) return m_phy;
        if (a == 8'h21) return m_ckq;
        if (a == 8'h22) begin
            if (m_phy[0]) return 8'h00;
            if (m_ckq[0]) return 8'h01;
            return {7'b0, m_trip[0][6]};
        end
        for (int i = 0; i < 4; i++)
            if (a >= t_base[i] && a <= t_base[i] + 8'd2) return m_trip[i];
        return 8'h00;
    endfunction

    function automatic void model_write(logic [7:0] a, logic [7:0] d);
        if (a == 8'h20) m_phy = d & 8'h01;
        if (a == 8'h21) m_ckq = d & 8'h07;
        for (int i = 0; i < 4; i++) begin
            if (a == t_base[i])        m_trip[i] = d & t_mask[i];
            if (a == t_base[i] + 8'd1) m_trip[i] = (m_trip[i] | d) & t_mask[i];
            if (a == t_base[i] + 8'd2) m_trip[i] = (m_trip[i] & ~d) & t_mask[i];
        end
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic sweep(string req);
        logic [7:0] v;
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), v);
            check(req, v, exp_read(8'(a)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pats [5] = '{8'hff, 8'h00, 8'ha5, 8'h5a, 8'h3c};
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        for (int i = 0; i < 4; i++) m_trip[i] = t_rst[i];
        m_phy = 8'h00; m_ckq = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 rdata", rdata, 8'h00);
        rst = 1'b0;
        // R1 R5 R9: full read sweep of reset state
        sweep("R1 R5 R9 reset sweep");

        // R2 R3 R4 R5 per triplet
        for (int i = 0; i < 4; i++) begin
            for (int p = 0; p < 5; p++) begin
                wr(t_base[i], pats[p]);
                rd(t_base[i], v);          check("R2 direct", v, exp_read(t_base[i]));
                wr(t_base[i] + 8'd1, pats[(p + 2) % 5]);
                rd(t_base[i] + 8'd1, v);   check("R3 set", v, exp_read(t_base[i]));
                wr(t_base[i] + 8'd2, pats[(p + 3) % 5]);
                rd(t_base[i] + 8'd2, v);   check("R4 clear", v, exp_read(t_base[i]));
            end
        end

        // R6 masks on PHY power and clock request
        wr(8'h20, 8'hfe); rd(8'h20, v); check("R6 phy", v, 8'h00);
        wr(8'h21, 8'hff); rd(8'h21, v); check("R6 ckq", v, 8'h07);

        // R7 all combinations of the three status sources
        for (int c = 0; c < 8; c++) begin
            wr(8'h20, {7'b0, c[2]});
            wr(8'h21, {7'b0, c[1]});
            wr(8'h10, {1'b0, c[0], 6'b0});
            rd(8'h22, v);
            check("R7 status", v, c[2] ? 8'h00 : (c[1] ? 8'h01 : {7'b0, c[0]}));
        end

        // R8 R9: writes to read-only and unimplemented addresses
        wr(8'h10, 8'h55); wr(8'h14, 8'hff); wr(8'h20, 8'h00); wr(8'h21, 8'h01);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] aa = 8'(a);
            bit live = (aa == 8'h20) || (aa == 8'h21);
            for (int i = 0; i < 4; i++)
                if (aa >= t_base[i] && aa <= t_base[i] + 8'd2) live = 1'b1;
            if (!live) wr(aa, 8'hff);
        end
        sweep("R8 R9 ignored writes");

        // R10: hold without strobe
        rd(8'h01, v);
        @(negedge clk); addr = 8'h14;
        repeat (3) @(negedge clk);
        check("R10 hold", rdata, 8'hc3);

        // R10: read and write together return the old value
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 8'h18; wdata = 8'h2a;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 same cycle", rdata, m_trip[2]);
        model_write(8'h18, 8'h2a);
        rd(8'h18, v); check("R10 after write", v, 8'h2a);

        // R1: reset again restores defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) m_trip[i] = t_rst[i];
        m_phy = 8'h00; m_ckq = 8'h00;
        check("R1 rdata after reset", rdata, 8'h00);
        for (int i = 0; i < 4; i++) begin
            rd(t_base[i], v); check("R1 reset value", v, t_rst[i]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule